// File: doc/BRIEF.md
# Instruction Address Range Breakpoint

This block compares every instruction fetch address with a range that software programs. When the address meets the selected condition, the block raises a one-cycle breakpoint event strobe. The condition is either inside the range or outside it, and both bounds are inclusive. The strobe is intended as the event-source input of a counting timer elsewhere on the chip, so that an interrupt is raised after a chosen number of matches. This block does not count events and does not raise interrupts.

Software programs three word registers through a simple write port, addressed by byte offset:

- A control word at offset 0x0. Bit 0 enables the breakpoint and bit 1 selects outside-range matching.
- The lower bound at offset 0x4.
- The upper bound at offset 0x8.

Reset clears the control word. The bound registers hold no defined value until they are written.

Top module: `ibrk_watch`

## Requirements
- R1: After reset the control word is zero, so no event is produced until software sets the enable bit, whatever the bound registers hold.
- R2: While control bit 0 (enable) is 0, the event output stays low for every fetch.
- R3: With enable set and control bit 1 (mode) at 0, a fetch produces an event when lower bound <= address <= upper bound, both bounds included.
- R4: With enable set and mode at 1, a fetch produces an event when address < lower bound or address > upper bound.
- R5: A cycle in which fetch-valid is low produces no event, whatever the address.
- R6: The event is registered. A qualifying fetch on clock edge N gives a high event output for exactly the cycle after edge N. Back-to-back qualifying fetches give one pulse per fetch.
- R7: If the lower bound is greater than the upper bound, inside mode never matches and outside mode matches every address.
- R8: All address and bound comparisons are unsigned 32-bit.
- R9: A write takes effect from the next edge. Byte offset 0x0 is the control word, 0x4 is the lower bound and 0x8 is the upper bound. A write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the control word |
| cfg_we | input | 1 | Register write strobe |
| cfg_off | input | 4 | Byte offset of the register written |
| cfg_wdata | input | 32 | Write data |
| fetch_valid | input | 1 | Instruction fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| brk_evt | output | 1 | One-cycle breakpoint event strobe |

## Verification
The checker restates the inside and outside conditions in unsigned arithmetic of its own. On every cycle it checks that the event follows exactly one cycle after a qualifying fetch, and that it stays low when enable or fetch-valid is low or when an inverted range is used in inside mode. The checker also confirms that the control word is clear as reset releases.

Some behaviours only the bench scenarios can show, because they are seen only at the ports:
- the register offsets and bit positions;
- that writes to an unused offset are ignored;
- inclusive edges at exactly the bound values;
- unsigned ordering across the top address bit;
- one pulse per fetch in a back-to-back run.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
  localparam int unsigned AW    = 32;
  localparam int unsigned OFF_W = 4;
  localparam int unsigned NBND  = 2;

  typedef logic [AW-1:0]    addr_t;
  typedef logic [OFF_W-1:0] off_t;

  localparam off_t OFF_CTL = 4'h0;
  localparam off_t OFF_LO  = 4'h4;
  localparam off_t OFF_HI  = 4'h8;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_MODE_BIT = 1;

  // byte offset of bound register i (0 = lower, 1 = upper)
  function automatic off_t bound_off(input int unsigned i);
    return (i == 0) ? OFF_LO : OFF_HI;
  endfunction

  // inclusive unsigned range test
  function automatic logic in_window(input addr_t lo, input addr_t hi, input addr_t a);
    return (a >= lo) && (a <= hi);
  endfunction

  // mode 0: inside, mode 1: strictly outside
  function automatic logic range_match(input logic mode, input addr_t lo,
                                       input addr_t hi, input addr_t a);
    if (mode) return (a < lo) || (a > hi);
    return in_window(lo, hi, a);
  endfunction
endpackage

// File: rtl/ibrk_regs.sv
module ibrk_regs
  import ibrk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cfg_we,
  input  off_t  cfg_off,
  input  addr_t cfg_wdata,
  output logic  ctl_en,
  output logic  ctl_mode,
  output addr_t bound_lo,
  output addr_t bound_hi
);
  addr_t bnd [NBND];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_mode <= 1'b0;
    end else if (cfg_we && cfg_off == OFF_CTL) begin
      ctl_en   <= cfg_wdata[CTL_EN_BIT];
      ctl_mode <= cfg_wdata[CTL_MODE_BIT];
    end
  end

  // bounds carry no reset value
  for (genvar i = 0; i < NBND; i++) begin : g_bnd
    always_ff @(posedge clk) begin
      if (cfg_we && cfg_off == bound_off(i)) bnd[i] <= cfg_wdata;
    end
  end

  assign bound_lo = bnd[0];
  assign bound_hi = bnd[1];
endmodule

// File: rtl/ibrk_cmp.sv
module ibrk_cmp
  import ibrk_pkg::*;
(
  input  logic  mode,
  input  addr_t lo,
  input  addr_t hi,
  input  addr_t addr,
  output logic  hit
);
  always_comb hit = range_match(mode, lo, hi, addr);
endmodule

// File: rtl/ibrk_watch.sv
module ibrk_watch
  import ibrk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [OFF_W-1:0] cfg_off,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             fetch_valid,
  input  logic [AW-1:0]    fetch_addr,
  output logic             brk_evt
);
  logic  ctl_en, ctl_mode, cmp_hit, evt_q;
  addr_t bound_lo, bound_hi;

  ibrk_regs i_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
    .bound_lo(bound_lo), .bound_hi(bound_hi)
  );

  ibrk_cmp i_cmp (
    .mode(ctl_mode), .lo(bound_lo), .hi(bound_hi),
    .addr(fetch_addr), .hit(cmp_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= fetch_valid && ctl_en && cmp_hit;
  end

  assign brk_evt = evt_q;
endmodule

// File: rtl/ibrk_watch_chk.sv
module ibrk_watch_chk
  import ibrk_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  fetch_valid,
  input addr_t fetch_addr,
  input logic  ctl_en,
  input logic  ctl_mode,
  input addr_t bound_lo,
  input addr_t bound_hi,
  input logic  brk_evt
);
  logic ins_ok, outs_ok, qual;
  assign ins_ok  = !(fetch_addr < bound_lo) && !(bound_hi < fetch_addr);
  assign outs_ok = !ins_ok;
  assign qual    = fetch_valid && ctl_en && (ctl_mode ? outs_ok : ins_ok);

  p_ctl_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> !ctl_en);
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !brk_evt);
  p_inside_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && ctl_en && !ctl_mode && ins_ok) |=> brk_evt);
  p_outside_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && ctl_en && ctl_mode && outs_ok) |=> brk_evt);
  p_no_fetch_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !brk_evt);
  p_evt_only_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> !brk_evt);
  p_inverted_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_mode && bound_lo > bound_hi) |=> !brk_evt);
endmodule

bind ibrk_watch ibrk_watch_chk i_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .ctl_en(ctl_en), .ctl_mode(ctl_mode), .bound_lo(bound_lo),
  .bound_hi(bound_hi), .brk_evt(brk_evt)
);

// File: tb/test_ibrk_watch.sv
`timescale 1ns/1ps
module test_ibrk_watch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_off = '0;
  logic [31:0] cfg_wdata = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        brk_evt;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ibrk_watch i_ibrk_watch (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .brk_evt(brk_evt)
  );

  typedef struct packed {
    logic        mode;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] addr;
    logic        exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'd100, 32'd200, 32'd100, 1'b1},             // R3 lower edge
    '{1'b0, 32'd100, 32'd200, 32'd200, 1'b1},             // R3 upper edge
    '{1'b0, 32'd100, 32'd200, 32'd99,  1'b0},             // R3
    '{1'b0, 32'd100, 32'd200, 32'd201, 1'b0},             // R3
    '{1'b1, 32'd100, 32'd200, 32'd99,  1'b1},             // R4
    '{1'b1, 32'd100, 32'd200, 32'd201, 1'b1},             // R4
    '{1'b1, 32'd100, 32'd200, 32'd100, 1'b0},             // R4 edge is inside
    '{1'b1, 32'd100, 32'd200, 32'd150, 1'b0},             // R4
    '{1'b0, 32'd200, 32'd100, 32'd150, 1'b0},             // R7 inside never
    '{1'b1, 32'd200, 32'd100, 32'd150, 1'b1},             // R7 outside always
    '{1'b0, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},   // R8
    '{1'b1, 32'd1, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1},   // R8 above, unsigned
    '{1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 32'd5, 1'b0}    // R8
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: brk_evt=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_off = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one fetch, sample the registered event one edge later
  task automatic fetch(input logic v, input logic [31:0] a, output logic got);
    @(negedge clk);
    fetch_valid = v; fetch_addr = a;
    @(negedge clk);
    got = brk_evt;
    fetch_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic g;
    repeat (3) @(negedge clk);
    check("R1 reset output", brk_evt, 1'b0);
    rst_n = 1'b1;
    // R1: bounds cover all, control never written
    wr(4'h4, 32'd0);
    wr(4'h8, 32'hFFFF_FFFF);
    fetch(1'b1, 32'h1234, g); check("R1 control cleared", g, 1'b0);
    // R2: mode bit only, enable bit 0 off
    wr(4'h0, 32'h2);
    fetch(1'b1, 32'h1234, g); check("R2 disabled outside", g, 1'b0);
    wr(4'h0, 32'h0);
    fetch(1'b1, 32'h1234, g); check("R2 disabled inside", g, 1'b0);
    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(4'h4, VEC[i].lo);
      wr(4'h8, VEC[i].hi);
      wr(4'h0, {30'd0, VEC[i].mode, 1'b1});
      fetch(1'b1, VEC[i].addr, g);
      check($sformatf("R3/R4/R7/R8 vector %0d", i), g, VEC[i].exp);
    end
    // R5: matching address but valid low
    wr(4'h4, 32'd10); wr(4'h8, 32'd20); wr(4'h0, 32'h1);
    fetch(1'b0, 32'd15, g); check("R5 valid low", g, 1'b0);
    // R6: back-to-back pulses, then drop
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = 32'd12;
    @(negedge clk); check("R6 first pulse", brk_evt, 1'b1);
    fetch_addr = 32'd18;
    @(negedge clk); check("R6 second pulse", brk_evt, 1'b1);
    fetch_addr = 32'd50;
    @(negedge clk); check("R6 non-match ends pulse", brk_evt, 1'b0);
    fetch_valid = 1'b0;
    @(negedge clk); check("R6 idle", brk_evt, 1'b0);
    // R9: unused offset ignored
    wr(4'hC, 32'h0);
    fetch(1'b1, 32'd15, g); check("R9 offset 0xC ignored", g, 1'b1);
    wr(4'h1, 32'h0);
    fetch(1'b1, 32'd15, g); check("R9 offset 0x1 ignored", g, 1'b1);
    wr(4'h0, 32'h3);
    fetch(1'b1, 32'd15, g); check("R9 mode bit1 outside", g, 1'b0);
    fetch(1'b1, 32'd25, g); check("R9 mode bit1 outside hit", g, 1'b1);
    // R1: reset again clears control
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    fetch(1'b1, 32'd25, g); check("R1 reset clears control", g, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule